// File: doc/BRIEF.md
# Interrupt Line Pending Logic

This block keeps, for every interrupt ID fed by an external hardware line, a stored copy of the line level and a pending bit. Each external line is passed through a two-flop synchronizer and then compared with its stored level. A sampled value that matches the stored copy is ignored. A mismatch is a rise or a fall. The trigger-mode and enable vectors from the register bank decide whether a rise makes the interrupt pending. A fall never clears pending.

The pending bitmap can also be changed by set and clear masks from the register bank, and by a single re-pend request from the completion tracker. After any change of level, any mask write or any accepted re-pend, the block sends the arbiter a one-cycle update pulse so that it re-evaluates priority.

External line k drives interrupt ID k + ID_BASE. The IDs below ID_BASE belong to internal sources. For those IDs only the mask writes can change pending.

Top module: `irq_line_pend`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the level bitmap, the pending bitmap and the update pulse are all zero.
- R2: External line k is held in bit k + ID_BASE of the level and pending bitmaps. Level bits below ID_BASE always read zero.
- R3: A change on a line reaches the level bitmap on the third rising clock edge after it settles. Two edges are spent in the synchronizer and one in the state register.
- R4: A sampled line equal to its stored level changes nothing. When no line changes and no mask or re-pend is applied, the update pulse stays low and both bitmaps hold their values.
- R5: On a rise the level bit is set. The pending bit is set when trigEdge for that ID is 1 (edge mode), even if enableBits is 0. With trigEdge 0 (level mode), pending is set only when enableBits is 1.
- R6: On a fall the level bit is cleared and the pending bit keeps its value.
- R7: The update pulse is high for exactly one cycle, in the cycle the new state first appears. It fires for any level change, for any non-zero set or clear mask, and for an accepted re-pend.
- R8: A set-mask bit sets pending and a clear-mask bit clears it. When any set source (set mask, rise, re-pend) and the clear mask hit the same ID in the same cycle, the bit ends up set.
- R9: A re-pend request for an ID sets its pending bit only if all of these hold: the ID is below NUM_IDS, the ID is in level mode, it is enabled, and its stored level is 1. A request that fails any of these changes nothing and gives no update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqLines | input | NUM_LINES | Raw external interrupt lines |
| trigEdge | input | NUM_IDS | Per-ID trigger mode: 1 = edge, 0 = level |
| enableBits | input | NUM_IDS | Per-ID enable: 1 = enabled |
| setPendMask | input | NUM_IDS | One-cycle strobe: set pending for each bit that is 1 |
| clrPendMask | input | NUM_IDS | One-cycle strobe: clear pending for each bit that is 1 |
| rependValid | input | 1 | One-cycle re-pend request from the completion tracker |
| rependId | input | ID_W | ID named by the re-pend request |
| levelMap | output | NUM_IDS | Stored line levels |
| pendMap | output | NUM_IDS | Pending bits |
| updatePulse | output | 1 | One-cycle request to the arbiter to re-evaluate |

## Verification
The bench sweeps every line of a small configuration through all four combinations of trigger mode and enable. This catches a design that gates edge-mode pending on enable, or one that lets a disabled level-mode line pend. It checks that a fall leaves pending in place, which catches logic that clears pending together with the level. It also checks that the update pulse lasts exactly one cycle and stays low while a line is held steady, which catches a design that reacts to the level rather than to a change.

The bench lands a clear mask on the same edge as a detected rise and also drives overlapping set and clear masks, which exposes clear winning over set. It drives re-pend requests for every combination of mode, enable and stored level, and for an ID that is out of range. This catches a design that accepts a re-pend unconditionally or raises an update pulse for a rejected one.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  // Depth of the input synchronizer chain.
  localparam int unsigned SYNC_STAGES = 2;

  // Summary strobes passed from the control to the datapath.
  // Any bit set means the arbiter must re-evaluate.
  typedef struct packed {
    logic lineChange;   // at least one stored level flips this cycle
    logic strobeWrite;  // a set or clear mask carries a non-zero value
    logic rependHit;    // a re-pend request passed its qualification
  } pendStrobes_t;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lineIn,
  output logic [WIDTH-1:0] lineOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stageQ[0] <= '0;
    else        stageQ[0] <= lineIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stageQ[s] <= '0;
      else        stageQ[s] <= stageQ[s-1];
    end
  end

  assign lineOut = stageQ[STAGES-1];

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ID_BASE   = 32,
  parameter int NUM_IDS   = ID_BASE + NUM_LINES,
  parameter int ID_W      = $clog2(NUM_IDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] syncLines,
  input  logic [NUM_IDS-1:0]   levelQ,
  input  logic [NUM_IDS-1:0]   trigEdge,
  input  logic [NUM_IDS-1:0]   enableBits,
  input  logic [NUM_IDS-1:0]   setPendMask,
  input  logic [NUM_IDS-1:0]   clrPendMask,
  input  logic                 rependValid,
  input  logic [ID_W-1:0]      rependId,
  output logic [NUM_IDS-1:0]   riseMask,
  output logic [NUM_IDS-1:0]   fallMask,
  output logic [NUM_IDS-1:0]   pendSet,
  output logic [NUM_IDS-1:0]   pendClr,
  output pendStrobes_t         strobes
);

  logic [NUM_IDS-1:0] lineAtId;
  logic [NUM_IDS-1:0] rependMask;
  logic               rependOk;

  // Place each synchronized line at its ID; internal IDs see a constant low.
  if (ID_BASE > 0) begin : g_offset
    assign lineAtId = {syncLines, {ID_BASE{1'b0}}};
  end else begin : g_direct
    assign lineAtId = syncLines;
  end

  // Act only on a difference against the stored level.
  assign riseMask = lineAtId & ~levelQ;
  assign fallMask = ~lineAtId & levelQ;

  // Re-pend qualification: level mode, enabled, line still high.
  always_comb begin
    rependMask = '0;
    rependOk   = 1'b0;
    if (rependValid && (32'(rependId) < NUM_IDS)) begin
      if (!trigEdge[rependId] && enableBits[rependId] && levelQ[rependId]) begin
        rependOk             = 1'b1;
        rependMask[rependId] = 1'b1;
      end
    end
  end

  // A rise pends if edge mode, or if enabled in level mode.
  assign pendSet = (riseMask & (trigEdge | enableBits)) | setPendMask | rependMask;
  // Set sources override the clear mask.
  assign pendClr = clrPendMask & ~pendSet;

  assign strobes.lineChange  = |(riseMask | fallMask);
  assign strobes.strobeWrite = (|setPendMask) | (|clrPendMask);
  assign strobes.rependHit   = rependOk;

  // R9: an accepted re-pend names an enabled level-mode ID whose level is high
  p_repend_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rependHit |-> (rependValid && (32'(rependId) < NUM_IDS)
                           && enableBits[rependId] && !trigEdge[rependId]
                           && levelQ[rependId]));

endmodule

// File: rtl/irq_pend_dp.sv
module irq_pend_dp
  import irq_pend_pkg::*;
#(
  parameter int NUM_IDS = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-1:0] riseMask,
  input  logic [NUM_IDS-1:0] fallMask,
  input  logic [NUM_IDS-1:0] pendSet,
  input  logic [NUM_IDS-1:0] pendClr,
  input  pendStrobes_t       strobes,
  output logic [NUM_IDS-1:0] levelQ,
  output logic [NUM_IDS-1:0] pendQ,
  output logic               updatePulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      levelQ      <= '0;
      pendQ       <= '0;
      updatePulse <= 1'b0;
    end else begin
      levelQ      <= (levelQ | riseMask) & ~fallMask;
      pendQ       <= (pendQ & ~pendClr) | pendSet;
      updatePulse <= |strobes;
    end
  end

  // R8: every bit named by a set source is pending in the next cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pendSet) |=> ((pendQ & $past(pendSet)) == $past(pendSet)));

  // R6: a falling line that was pending stays pending unless explicitly cleared
  p_fall_keeps_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fallMask & pendQ & ~pendClr))
      |=> ((pendQ & $past(fallMask & pendQ & ~pendClr))
           == $past(fallMask & pendQ & ~pendClr)));

endmodule

// File: rtl/irq_line_pend.sv
module irq_line_pend
  import irq_pend_pkg::*;
#(
  parameter  int NUM_LINES = 64,
  parameter  int ID_BASE   = 32,
  localparam int NUM_IDS   = ID_BASE + NUM_LINES,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [NUM_IDS-1:0]   trigEdge,
  input  logic [NUM_IDS-1:0]   enableBits,
  input  logic [NUM_IDS-1:0]   setPendMask,
  input  logic [NUM_IDS-1:0]   clrPendMask,
  input  logic                 rependValid,
  input  logic [ID_W-1:0]      rependId,
  output logic [NUM_IDS-1:0]   levelMap,
  output logic [NUM_IDS-1:0]   pendMap,
  output logic                 updatePulse
);

  logic [NUM_LINES-1:0] syncLines;
  logic [NUM_IDS-1:0]   riseMask;
  logic [NUM_IDS-1:0]   fallMask;
  logic [NUM_IDS-1:0]   pendSet;
  logic [NUM_IDS-1:0]   pendClr;
  pendStrobes_t         strobes;

  irq_line_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .lineIn  (irqLines),
    .lineOut (syncLines)
  );

  irq_pend_ctrl #(
    .NUM_LINES (NUM_LINES),
    .ID_BASE   (ID_BASE),
    .NUM_IDS   (NUM_IDS),
    .ID_W      (ID_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .syncLines   (syncLines),
    .levelQ      (levelMap),
    .trigEdge    (trigEdge),
    .enableBits  (enableBits),
    .setPendMask (setPendMask),
    .clrPendMask (clrPendMask),
    .rependValid (rependValid),
    .rependId    (rependId),
    .riseMask    (riseMask),
    .fallMask    (fallMask),
    .pendSet     (pendSet),
    .pendClr     (pendClr),
    .strobes     (strobes)
  );

  irq_pend_dp #(
    .NUM_IDS (NUM_IDS)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .riseMask    (riseMask),
    .fallMask    (fallMask),
    .pendSet     (pendSet),
    .pendClr     (pendClr),
    .strobes     (strobes),
    .levelQ      (levelMap),
    .pendQ       (pendMap),
    .updatePulse (updatePulse)
  );

  // R3: the stored levels follow the synchronized lines one edge later
  p_level_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (levelMap[NUM_IDS-1:ID_BASE] == $past(syncLines)));

  // R4: a quiet cycle produces no update and leaves the pending map alone
  p_quiet_no_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((syncLines == levelMap[NUM_IDS-1:ID_BASE]) && (setPendMask == '0)
      && (clrPendMask == '0) && !rependValid)
      |=> (!updatePulse && $stable(pendMap)));

  if (ID_BASE > 0) begin : g_low_chk
    // R2: internal IDs never show a line level
    p_low_ids_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      levelMap[ID_BASE-1:0] == '0);
  end

endmodule

// File: tb/irq_line_pend_test.sv
`timescale 1ns/1ps
module irq_line_pend_test;

  localparam int NL = 8;
  localparam int IB = 32;
  localparam int NI = IB + NL;
  localparam int IW = $clog2(NI);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [NI-1:0] trigEdge = '0;
  logic [NI-1:0] enableBits = '0;
  logic [NI-1:0] setMask = '0;
  logic [NI-1:0] clrMask = '0;
  logic          rependValid = 1'b0;
  logic [IW-1:0] rependId = '0;
  wire  [NI-1:0] levelMap;
  wire  [NI-1:0] pendMap;
  wire           updatePulse;

  int nRun = 0;
  int nFail = 0;
  logic [NI-1:0] expPend = '0;

  always #4 clk = ~clk;

  irq_line_pend #(.NUM_LINES(NL), .ID_BASE(IB)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irqLines    (lines),
    .trigEdge    (trigEdge),
    .enableBits  (enableBits),
    .setPendMask (setMask),
    .clrPendMask (clrMask),
    .rependValid (rependValid),
    .rependId    (rependId),
    .levelMap    (levelMap),
    .pendMap     (pendMap),
    .updatePulse (updatePulse)
  );

  task automatic chkVec(input string req, input logic [NI-1:0] act, input logic [NI-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    clrMask = '1;
    cyc(1);
    clrMask = '0;
    expPend = '0;
    cyc(1);
  endtask

  function automatic logic [NI-1:0] mix(input int seed, input int salt);
    logic [63:0] h;
    h = 64'h9E3779B97F4A7C15 * 64'(seed + 1) + 64'(salt) * 64'hC2B2AE3D27D4EB4F;
    return NI'(h >> 11);
  endfunction

  initial begin : watchdog
    #1200000;
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    // R1: reset state
    cyc(3);
    chkVec("R1 level in reset", levelMap, '0);
    chkVec("R1 pend in reset", pendMap, '0);
    chkBit("R1 update in reset", updatePulse, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chkVec("R1 level after reset", levelMap, '0);
    chkVec("R1 pend after reset", pendMap, '0);
    chkBit("R1 update after reset", updatePulse, 1'b0);

    // R2 R3 R4 R5 R6 R7: every line under every mode/enable combination
    for (int k = 0; k < NL; k++) begin
      for (int m = 0; m < 4; m++) begin
        trigEdge = '0;
        enableBits = '0;
        trigEdge[IB+k] = m[1];
        enableBits[IB+k] = m[0];
        clearAll();
        lines[k] = 1'b1;
        cyc(2);
        chkVec("R3 level not yet visible", levelMap, '0);
        cyc(1);
        chkVec("R2 R5 level set at k+ID_BASE", levelMap, NI'(1) << (IB + k));
        expPend = (m[1] | m[0]) ? (NI'(1) << (IB + k)) : '0;
        chkVec("R5 pend on rise by mode/enable", pendMap, expPend);
        chkBit("R7 update on rise", updatePulse, 1'b1);
        cyc(1);
        chkBit("R7 update lasts one cycle", updatePulse, 1'b0);
        cyc(3);
        chkBit("R4 steady line no update", updatePulse, 1'b0);
        chkVec("R4 steady line level held", levelMap, NI'(1) << (IB + k));
        lines[k] = 1'b0;
        cyc(3);
        chkVec("R6 level cleared on fall", levelMap, '0);
        chkVec("R6 pend kept on fall", pendMap, expPend);
        chkBit("R7 update on fall", updatePulse, 1'b1);
        cyc(1);
      end
    end

    // R8 R7 R4: set/clear mask patterns tracked arithmetically
    trigEdge = '0;
    enableBits = '0;
    clearAll();
    for (int p = 0; p < 24; p++) begin
      logic [NI-1:0] sv;
      logic [NI-1:0] cv;
      sv = (p % 8 == 7) ? '0 : mix(p, 1);
      cv = (p % 8 == 7) ? '0 : (mix(p, 2) | (sv & mix(p, 3)));
      setMask = sv;
      clrMask = cv;
      cyc(1);
      setMask = '0;
      clrMask = '0;
      expPend = (expPend & ~cv) | sv;
      chkVec("R8 pend after masks, set wins", pendMap, expPend);
      chkBit("R7 R4 update follows mask activity", updatePulse, (sv | cv) != '0);
    end
    cyc(1);
    chkBit("R4 idle after masks", updatePulse, 1'b0);

    // R8: clear mask on the same edge as a detected rise
    trigEdge = '0;
    trigEdge[IB+3] = 1'b1;
    clearAll();
    lines[3] = 1'b1;
    cyc(2);
    clrMask[IB+3] = 1'b1;
    cyc(1);
    clrMask = '0;
    chkVec("R8 rise beats same-cycle clear", pendMap, NI'(1) << (IB + 3));
    lines[3] = 1'b0;
    cyc(4);

    // R9: re-pend qualification over mode, enable, stored level
    for (int m = 0; m < 8; m++) begin
      trigEdge = '0;
      enableBits = '0;
      trigEdge[IB+1] = m[2];
      enableBits[IB+1] = m[1];
      lines[1] = m[0];
      cyc(4);
      clearAll();
      rependValid = 1'b1;
      rependId = IW'(IB + 1);
      cyc(1);
      rependValid = 1'b0;
      expPend = (!m[2] && m[1] && m[0]) ? (NI'(1) << (IB + 1)) : '0;
      chkVec("R9 re-pend by mode/enable/level", pendMap, expPend);
      chkBit("R9 update only when accepted", updatePulse, expPend != '0);
      lines[1] = 1'b0;
      cyc(4);
    end

    // R9: out-of-range ID and internal ID with no line level
    trigEdge = '0;
    enableBits = '1;
    clearAll();
    rependValid = 1'b1;
    rependId = IW'(NI + 5);
    cyc(1);
    rependValid = 1'b0;
    chkVec("R9 out-of-range re-pend ignored", pendMap, '0);
    chkBit("R9 out-of-range re-pend no update", updatePulse, 1'b0);
    rependValid = 1'b1;
    rependId = IW'(5);
    cyc(1);
    rependValid = 1'b0;
    chkVec("R9 internal ID re-pend ignored", pendMap, '0);
    chkBit("R9 internal ID re-pend no update", updatePulse, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule